// File: doc/BRIEF.md
# DMA Channel Interrupt Aggregator

This block collects completion events from sixteen DMA channels and turns them into one interrupt line. Channels 0 to 7 belong to the first channel family and channels 8 to 15 to the second. Each channel reports two kinds of event as single-cycle pulses: a half-way event, when half of its transfer is done, and a final event, when the whole transfer is done. Each event is latched into its own sticky pending flag. Together the sixteen channels fill a 32-bit status word, two bits per channel.

Software sees two 32-bit registers through a simple register port. The enable mask is at offset 0x0 and is an ordinary read/write register. The pending word is at offset 0x4. Software clears a pending bit by writing a one to it. Any enabled pending bit raises the interrupt output. The register port is plain control: a write takes effect in the cycle it is presented, and a read answers one cycle later with a valid strobe. There is no back-pressure on the port.

Top module: `dma_irq_ctrl`

## Requirements
- R1: After reset the enable mask and the pending word both read as zero, `irq_o` is low and `rd_valid_o` is low.
- R2: A half-way pulse on channel n sets pending bit 2n, and a final pulse on channel n sets bit 2n+1. Channels 0..7 (first family) and 8..15 (second family) together cover bits 0..31.
- R3: An event pulse sets its pending bit whatever the enable mask holds. With a zero mask, `irq_o` stays low.
- R4: A write to offset 0x4 clears every pending bit whose data bit is 1 and leaves every bit whose data bit is 0 unchanged.
- R5: When an event pulse and a write-one clear reach the same pending bit in the same cycle, the bit ends up set.
- R6: A write to offset 0x0 loads all 32 enable bits from the write data, and a read of offset 0x0 returns them exactly.
- R7: `irq_o` is high in cycle t+1 exactly when (pending AND enable) is nonzero in cycle t.
- R8: `rd_en_i` in cycle t gives `rd_valid_o` high in cycle t+1, with the register contents as they were before any write in cycle t.
- R9: A write to any offset other than 0x0 or 0x4 changes neither register, and a read of such an offset returns zero.
- R10: `rd_data_o` is zero in every cycle in which `rd_valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| half_evt_i | input | 16 | Half-way event pulses, one per channel |
| end_evt_i | input | 16 | Final event pulses, one per channel |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 8 | Byte offset of the access |
| wdata_i | input | 32 | Write data |
| rd_valid_o | output | 1 | Read data valid, one cycle after `rd_en_i` |
| rd_data_o | output | 32 | Read data, zero when not valid |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The bench builds the block with its default parameters: eight channels in each family, an 8-bit offset and the registers at 0x0 and 0x4. With these values all 32 status bits exist, so every channel's two events can be pulsed and read back one at a time, and an all-ones event pattern fills the word. The 8-bit offset lets the bench reach unmapped offsets (0x08, 0x01, 0xFC) for the ignored-write and zero-read cases. Directed sequences cover the same-cycle set/clear race and a read in the same cycle as a write, and a long random stretch mixes events, clears and mask changes.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;

  // Which register an access targets.
  typedef enum logic [1:0] {
    SEL_NONE    = 2'd0,
    SEL_ENABLE  = 2'd1,
    SEL_PENDING = 2'd2
  } reg_sel_e;

  localparam int BITS_PER_CH = 2;

endpackage

// File: rtl/dma_irq_decode.sv
module dma_irq_decode
  import dma_irq_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int OFF_ENABLE  = 0,
  parameter int OFF_PENDING = 4
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  output reg_sel_e          sel_o,
  output logic              wr_enable_o,
  output logic              wr_pending_o
);

  localparam logic [ADDR_W-1:0] ADDR_EN = ADDR_W'(OFF_ENABLE);
  localparam logic [ADDR_W-1:0] ADDR_PD = ADDR_W'(OFF_PENDING);

  always_comb begin
    if (addr_i == ADDR_EN)      sel_o = SEL_ENABLE;
    else if (addr_i == ADDR_PD) sel_o = SEL_PENDING;
    else                        sel_o = SEL_NONE;
  end

  assign wr_enable_o  = wr_en_i && (sel_o == SEL_ENABLE);
  assign wr_pending_o = wr_en_i && (sel_o == SEL_PENDING);

endmodule

// File: rtl/dma_irq_flag.sv
module dma_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);

  // A set in the same cycle as a clear wins.
  always_ff @(posedge clk) begin
    if (!rst_n)     q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end

endmodule

// File: rtl/dma_irq_pending.sv
module dma_irq_pending
  import dma_irq_pkg::*;
#(
  parameter int NUM_CH = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_CH-1:0]             half_evt_i,
  input  logic [NUM_CH-1:0]             end_evt_i,
  input  logic                          clr_en_i,
  input  logic [BITS_PER_CH*NUM_CH-1:0] clr_mask_i,
  output logic [BITS_PER_CH*NUM_CH-1:0] pend_o
);

  // Channel n owns bit 2n (half-way) and bit 2n+1 (final).
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    dma_irq_flag u_half (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (half_evt_i[ch]),
      .clr_i (clr_en_i & clr_mask_i[BITS_PER_CH*ch]),
      .q_o   (pend_o[BITS_PER_CH*ch])
    );
    dma_irq_flag u_final (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (end_evt_i[ch]),
      .clr_i (clr_en_i & clr_mask_i[BITS_PER_CH*ch+1]),
      .q_o   (pend_o[BITS_PER_CH*ch+1])
    );
  end

endmodule

// File: rtl/dma_irq_enable.sv
module dma_irq_enable #(
  parameter int REG_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [REG_W-1:0] data_i,
  output logic [REG_W-1:0] en_o
);

  always_ff @(posedge clk) begin
    if (!rst_n)      en_o <= '0;
    else if (load_i) en_o <= data_i;
  end

endmodule

// File: rtl/dma_irq_rdport.sv
module dma_irq_rdport
  import dma_irq_pkg::*;
#(
  parameter int REG_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_en_i,
  input  reg_sel_e         sel_i,
  input  logic [REG_W-1:0] en_i,
  input  logic [REG_W-1:0] pend_i,
  output logic             rd_valid_o,
  output logic [REG_W-1:0] rd_data_o
);

  logic [REG_W-1:0] mux_d;

  always_comb begin
    unique case (sel_i)
      SEL_ENABLE:  mux_d = en_i;
      SEL_PENDING: mux_d = pend_i;
      default:     mux_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
    end else begin
      rd_valid_o <= rd_en_i;
      rd_data_o  <= rd_en_i ? mux_d : '0;
    end
  end

endmodule

// File: rtl/dma_irq_ctrl.sv
module dma_irq_ctrl
  import dma_irq_pkg::*;
#(
  parameter int NUM_FAM_A   = 8,
  parameter int NUM_FAM_B   = 8,
  parameter int ADDR_W      = 8,
  parameter int OFF_ENABLE  = 0,
  parameter int OFF_PENDING = 4,
  localparam int NUM_CH     = NUM_FAM_A + NUM_FAM_B,
  localparam int REG_W      = BITS_PER_CH * NUM_CH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] half_evt_i,
  input  logic [NUM_CH-1:0] end_evt_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic              rd_valid_o,
  output logic [REG_W-1:0]  rd_data_o,
  output logic              irq_o
);

  reg_sel_e         sel;
  logic             wr_enable;
  logic             wr_pending;
  logic [REG_W-1:0] en_q;
  logic [REG_W-1:0] pend_q;

  dma_irq_decode #(
    .ADDR_W      (ADDR_W),
    .OFF_ENABLE  (OFF_ENABLE),
    .OFF_PENDING (OFF_PENDING)
  ) u_decode (
    .addr_i       (addr_i),
    .wr_en_i      (wr_en_i),
    .sel_o        (sel),
    .wr_enable_o  (wr_enable),
    .wr_pending_o (wr_pending)
  );

  dma_irq_enable #(.REG_W(REG_W)) u_enable (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (wr_enable),
    .data_i (wdata_i),
    .en_o   (en_q)
  );

  dma_irq_pending #(.NUM_CH(NUM_CH)) u_pending (
    .clk        (clk),
    .rst_n      (rst_n),
    .half_evt_i (half_evt_i),
    .end_evt_i  (end_evt_i),
    .clr_en_i   (wr_pending),
    .clr_mask_i (wdata_i),
    .pend_o     (pend_q)
  );

  dma_irq_rdport #(.REG_W(REG_W)) u_rdport (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_en_i    (rd_en_i),
    .sel_i      (sel),
    .en_i       (en_q),
    .pend_i     (pend_q),
    .rd_valid_o (rd_valid_o),
    .rd_data_o  (rd_data_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= |(pend_q & en_q);
  end

endmodule

// File: rtl/dma_irq_ctrl_chk.sv
module dma_irq_ctrl_chk #(
  parameter int NUM_CH      = 16,
  parameter int ADDR_W      = 8,
  parameter int OFF_ENABLE  = 0,
  parameter int OFF_PENDING = 4,
  localparam int REG_W      = 2 * NUM_CH
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CH-1:0] half_evt_i,
  input logic [NUM_CH-1:0] end_evt_i,
  input logic              wr_en_i,
  input logic              rd_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [REG_W-1:0]  wdata_i,
  input logic              rd_valid_o,
  input logic [REG_W-1:0]  rd_data_o,
  input logic              irq_o,
  input logic [REG_W-1:0]  en_q,
  input logic [REG_W-1:0]  pend_q
);

  logic [REG_W-1:0] ev;
  always_comb begin
    for (int n = 0; n < NUM_CH; n++) begin
      ev[2*n]   = half_evt_i[n];
      ev[2*n+1] = end_evt_i[n];
    end
  end

  logic wr_pd, wr_other;
  assign wr_pd    = wr_en_i && (addr_i == ADDR_W'(OFF_PENDING));
  assign wr_other = wr_en_i && (addr_i != ADDR_W'(OFF_ENABLE));

  // R5: an event always leaves its bit set
  a_r5_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (|ev) |=> ((pend_q & $past(ev)) == $past(ev)));

  // R3: pending bits rise only from events
  a_r3_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(ev)) == '0));

  // R4: cleared bits without an event drop
  a_r4_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pd |=> ((pend_q & $past(wdata_i & ~ev)) == '0));

  // R9: mask untouched by writes elsewhere
  a_r9_mask_stable: assert property (@(posedge clk) disable iff (!rst_n)
    wr_other |=> $stable(en_q));

  // R7: interrupt follows enabled pending with one cycle of delay
  a_r7_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_o == $past(|(pend_q & en_q))));

  // R8: read answers one cycle later
  a_r8_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (rd_valid_o == $past(rd_en_i)));

  // R10: idle read data is zero
  a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid_o |-> (rd_data_o == '0));

endmodule

bind dma_irq_ctrl dma_irq_ctrl_chk #(
  .NUM_CH      (NUM_CH),
  .ADDR_W      (ADDR_W),
  .OFF_ENABLE  (OFF_ENABLE),
  .OFF_PENDING (OFF_PENDING)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .half_evt_i (half_evt_i),
  .end_evt_i  (end_evt_i),
  .wr_en_i    (wr_en_i),
  .rd_en_i    (rd_en_i),
  .addr_i     (addr_i),
  .wdata_i    (wdata_i),
  .rd_valid_o (rd_valid_o),
  .rd_data_o  (rd_data_o),
  .irq_o      (irq_o),
  .en_q       (en_q),
  .pend_q     (pend_q)
);

// File: tb/tb_dma_irq_ctrl.sv
module tb_dma_irq_ctrl;
  localparam int NCH = 16;
  localparam int W   = 32;
  localparam int AW  = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic           rst_n;
  logic [NCH-1:0] half_evt, end_evt;
  logic           wr_en, rd_en;
  logic [AW-1:0]  addr;
  logic [W-1:0]   wdata;
  logic           rd_valid;
  logic [W-1:0]   rd_data;
  logic           irq;

  dma_irq_ctrl dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .half_evt_i (half_evt),
    .end_evt_i  (end_evt),
    .wr_en_i    (wr_en),
    .rd_en_i    (rd_en),
    .addr_i     (addr),
    .wdata_i    (wdata),
    .rd_valid_o (rd_valid),
    .rd_data_o  (rd_data),
    .irq_o      (irq)
  );

  int    n_chk  = 0;
  int    n_fail = 0;
  bit    done   = 0;
  string cur_req = "R1";

  // behavioural reference state
  logic [W-1:0] m_en, m_pend, m_rd;
  logic         m_irq, m_rv;

  task automatic check(string req, string what, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  // Model update from the inputs sampled at the edge, then compare.
  task automatic cycle();
    logic [W-1:0] set_v, clr_v, nrd;
    @(posedge clk);
    if (!rst_n) begin
      m_en = '0; m_pend = '0; m_irq = 1'b0; m_rv = 1'b0; m_rd = '0;
    end else begin
      for (int n = 0; n < NCH; n++) begin
        set_v[2*n]   = half_evt[n];
        set_v[2*n+1] = end_evt[n];
      end
      clr_v = (wr_en && addr == 8'h04) ? wdata : '0;
      nrd   = '0;
      if (rd_en) nrd = (addr == 8'h00) ? m_en : (addr == 8'h04) ? m_pend : '0;
      m_irq = |(m_pend & m_en);
      m_rv  = rd_en;
      m_rd  = nrd;
      m_pend = (m_pend & ~clr_v) | set_v;
      if (wr_en && addr == 8'h00) m_en = wdata;
    end
    @(negedge clk);
    check((cur_req == "R1") ? "R1" : "R7", {cur_req, " irq"}, W'(irq), W'(m_irq));
    check((cur_req == "R1") ? "R1" : "R8", {cur_req, " rd_valid"}, W'(rd_valid), W'(m_rv));
    check((cur_req == "R9") ? "R9" : "R10", {cur_req, " rd_data"}, rd_data, m_rd);
  endtask

  task automatic idle();
    half_evt = '0; end_evt = '0; wr_en = 0; rd_en = 0; addr = '0; wdata = '0;
  endtask

  task automatic wr(logic [AW-1:0] a, logic [W-1:0] d);
    idle(); wr_en = 1; addr = a; wdata = d; cycle(); idle();
  endtask

  task automatic rd(logic [AW-1:0] a);
    idle(); rd_en = 1; addr = a; cycle(); idle(); cycle();
  endtask

  task automatic pulse(logic [NCH-1:0] h, logic [NCH-1:0] e);
    idle(); half_evt = h; end_evt = e; cycle(); idle();
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
      $finish;
    end
  end

  initial begin
    rst_n = 0; idle();
    m_en = '0; m_pend = '0; m_irq = 0; m_rv = 0; m_rd = '0;
    @(negedge clk);
    // R1: reset state
    cur_req = "R1";
    repeat (4) cycle();
    rst_n = 1;
    rd(8'h00); rd(8'h04);

    // R6: enable register read/write
    cur_req = "R6";
    wr(8'h00, 32'hA5A5_0F0F); rd(8'h00);
    wr(8'h00, 32'h0000_0000); rd(8'h00);

    // R3: events latch with a zero mask, no interrupt
    cur_req = "R3";
    pulse(16'h0008, 16'h1000); cycle(); cycle(); rd(8'h04);
    wr(8'h04, 32'hFFFF_FFFF); rd(8'h04);

    // R2: bit mapping for every channel of both families
    cur_req = "R2";
    for (int ch = 0; ch < NCH; ch++) begin
      pulse(NCH'(1) << ch, '0); rd(8'h04); wr(8'h04, 32'hFFFF_FFFF);
      pulse('0, NCH'(1) << ch); rd(8'h04); wr(8'h04, 32'hFFFF_FFFF);
    end
    pulse('1, '1); rd(8'h04);

    // R4: write-one clears, zero keeps
    cur_req = "R4";
    wr(8'h04, 32'h0000_FFFF); rd(8'h04);
    wr(8'h04, 32'h0000_0000); rd(8'h04);
    wr(8'h04, 32'hFFFF_FFFF); rd(8'h04);

    // R5: same-cycle event and clear
    cur_req = "R5";
    idle(); end_evt = 16'h0020; wr_en = 1; addr = 8'h04; wdata = 32'hFFFF_FFFF;
    cycle(); idle(); rd(8'h04);

    // R7: interrupt timing
    cur_req = "R7";
    wr(8'h00, 32'h0000_0800); cycle(); cycle();
    wr(8'h04, 32'h0000_0800); cycle(); cycle();
    pulse(16'h0001, '0); cycle();
    wr(8'h00, 32'h0000_0001); cycle(); cycle();
    wr(8'h00, 32'h0); cycle();
    wr(8'h04, 32'hFFFF_FFFF);

    // R8: read in the same cycle as a write returns old contents
    cur_req = "R8";
    wr(8'h00, 32'h1234_5678);
    idle(); wr_en = 1; rd_en = 1; addr = 8'h00; wdata = 32'hCAFE_F00D; cycle(); idle(); cycle();
    rd(8'h00);
    pulse(16'h0002, '0);
    idle(); wr_en = 1; rd_en = 1; addr = 8'h04; wdata = 32'hFFFF_FFFF; cycle(); idle(); cycle();
    rd(8'h04);

    // R9: other offsets ignored and read as zero
    cur_req = "R9";
    pulse(16'h0100, '0);
    wr(8'h08, 32'hFFFF_FFFF); wr(8'h01, 32'hFFFF_FFFF); wr(8'hFC, 32'h0);
    rd(8'h08); rd(8'h01); rd(8'hFC); rd(8'h00); rd(8'h04);
    wr(8'h04, 32'hFFFF_FFFF);

    // R10: random traffic, data zero whenever not valid
    cur_req = "R10";
    for (int i = 0; i < 600; i++) begin
      idle();
      half_evt = NCH'($urandom) & NCH'($urandom);
      end_evt  = NCH'($urandom) & NCH'($urandom);
      case ($urandom % 4)
        0: begin wr_en = 1; addr = 8'h00; wdata = $urandom; end
        1: begin wr_en = 1; addr = 8'h04; wdata = $urandom; end
        default: ;
      endcase
      if ($urandom % 3 == 0) begin
        rd_en = 1;
        if (!wr_en) addr = ($urandom % 2) ? 8'h04 : 8'h00;
      end
      cycle();
    end
    idle(); cycle();

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule